// File: doc/BRIEF.md
# Stereo Sample FIFO with Threshold Interrupt

This block buffers left/right audio sample pairs that an I2S receiver delivers, until a processor reads them out. A pair is written with a single valid strobe. A read strobe takes the oldest pair off the queue and places it on a held output register. The block reports three things: the number of stored pairs, a full flag, and an interrupt request. The request tracks a fill threshold that software picks from one pair, half the capacity, or the whole capacity.

When the queue is already full, an arriving pair is not dropped. It replaces the most recently stored pair, so the processor always finds the freshest audio at the tail. A synchronous clear input empties the queue. Bus register decoding and the interrupt controller sit outside this block.

Top module: `stereo_sample_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 4) pairs. `level` gives the number stored, and reads return pairs oldest first.
- R2: After reset, `level` is 0, `full` is 0, `irq` is 0, and both read outputs are 0.
- R3: With `irq_mode` 2'b00 (half full, the all-zero code) or 2'b11, `irq` is 1 exactly while `level` is at least DEPTH/2.
- R4: With `irq_mode` 2'b01 (whole full), `irq` is 1 exactly while `level` equals DEPTH.
- R5: With `irq_mode` 2'b10 (one pair), `irq` is 1 exactly while `level` is at least 1.
- R6: `irq` is a level signal decoded from the current `level` and `irq_mode`. It falls in the same cycle that reads bring `level` below the threshold.
- R7: `full` goes to 1 one clock after a write that brings `level` to DEPTH. It also goes to 1 after a write that overwrites while the queue is at DEPTH.
- R8: A read strobe on a non-empty queue clears `full` to 0 on the next clock.
- R9: A write without a read while `level` equals DEPTH replaces the newest stored pair. `level` stays at DEPTH, and the older pairs are unchanged.
- R10: A read and a write in the same cycle on a non-empty queue leave `level` unchanged. At DEPTH, the oldest pair is read out and the new pair is appended.
- R11: A read strobe on an empty queue changes neither the read outputs nor `level`.
- R12: `clr` empties the queue and clears `full` on the next clock, taking priority over a read or write in that cycle. The read outputs keep their value.
- R13: `rd_left` and `rd_right` change one clock after an accepted read strobe and then hold until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous queue clear |
| irq_mode | input | 2 | Threshold select: 00 half, 01 whole, 10 one, 11 half |
| wr_valid | input | 1 | Write strobe for one pair |
| wr_left | input | SAMPLE_W | Left sample to store |
| wr_right | input | SAMPLE_W | Right sample to store |
| rd_strobe | input | 1 | Read strobe: take oldest pair |
| rd_left | output | SAMPLE_W | Left sample of last pair read |
| rd_right | output | SAMPLE_W | Right sample of last pair read |
| level | output | $clog2(DEPTH+1) | Number of stored pairs |
| full | output | 1 | Full flag |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with SAMPLE_W = 16 and the default DEPTH = 4. This is the narrower sample width, and it keeps the three thresholds distinct at 1, 2 and 4. At that depth, four writes reach the overwrite path, the full-queue simultaneous read and write, and every threshold crossing. The bench sweeps all four mode codes at every fill level, both while filling and while draining, and confirms the overwritten slot by the order of the data read back.

// File: rtl/sfifo_pkg.sv
// Package: shared interrupt mode encoding and threshold decode for the
// stereo sample FIFO. Assumes DEPTH is even and at least 2.
package sfifo_pkg;

    typedef enum logic [1:0] {
        IRQ_HALF  = 2'b00,
        IRQ_WHOLE = 2'b01,
        IRQ_ONE   = 2'b10,
        IRQ_RSVD  = 2'b11
    } irq_mode_e;

    // Returns the pair count at which the request rises for a mode.
    function automatic int unsigned irq_threshold(input irq_mode_e mode,
                                                  input int unsigned depth);
        case (mode)
            IRQ_WHOLE: return depth;
            IRQ_ONE:   return 1;
            default:   return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/sfifo_store.sv
// Storage array: DEPTH entries of one stereo pair each, one write port and
// one combinational read port. Assumes the controller never writes and reads
// the same slot expecting the new value in the same cycle.
module sfifo_store #(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH    = 4,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int PAIR_W  = 2 * SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [PAIR_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [PAIR_W-1:0] rdata
);

    logic [PAIR_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Holds one pair; loads when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (we && (waddr == PTR_W'(g))) begin
                slot[g] <= wdata;
            end
        end
    end

    // Presents the slot addressed by the read pointer.
    always_comb begin
        rdata = slot[raddr];
    end

endmodule

// File: rtl/sfifo_ctrl.sv
// Queue controller: owns pointers, fill count and the full flag, and decides
// between appending and overwriting the newest slot. Assumes DEPTH is a
// power of two so pointers wrap naturally.
module sfifo_ctrl #(
    parameter int DEPTH   = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_valid,
    input  logic             rd_strobe,
    output logic             we,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] raddr,
    output logic             pop,
    output logic [CNT_W-1:0] count,
    output logic             full_flag
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push;
    logic             at_cap;
    logic             empty;
    logic             overwrite;
    logic             append;

    // Classifies this cycle's request into pop, append or overwrite.
    always_comb begin
        at_cap    = (count == CNT_W'(DEPTH));
        empty     = (count == '0);
        pop       = rd_strobe && !empty && !clr;
        push      = wr_valid && !clr;
        overwrite = push && at_cap && !pop;
        append    = push && !overwrite;
        we        = push;
        waddr     = overwrite ? (wr_ptr - 1'b1) : wr_ptr;
        raddr     = rd_ptr;
    end

    // Advances the tail pointer on each append.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
        end else if (append) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Advances the head pointer on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Tracks the number of stored pairs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (append && !pop) begin
            count <= count + 1'b1;
        end else if (pop && !append) begin
            count <= count - 1'b1;
        end
    end

    // Full flag: set on reaching capacity or overwriting, cleared by reads.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full_flag <= 1'b0;
        end else if (pop) begin
            full_flag <= 1'b0;
        end else if (overwrite || (append && count == CNT_W'(DEPTH - 1))) begin
            full_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/sfifo_irq.sv
// Interrupt decode: compares the fill count against the threshold picked by
// the mode input. Purely combinational; assumes count never exceeds DEPTH.
module sfifo_irq #(
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    output logic             req
);
    import sfifo_pkg::*;

    logic [CNT_W-1:0] thr;

    // Raises the request while the count is at or above the threshold.
    always_comb begin
        thr = CNT_W'(irq_threshold(irq_mode_e'(mode), DEPTH));
        req = (count >= thr);
    end

endmodule

// File: rtl/stereo_sample_fifo.sv
// Top: stereo sample FIFO with selectable threshold interrupt and
// overwrite-newest on overflow. Read data is registered and held between
// reads. Assumes DEPTH is a power of two, at least 2.
module stereo_sample_fifo #(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH    = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [1:0]          irq_mode,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    input  logic                rd_strobe,
    output logic [SAMPLE_W-1:0] rd_left,
    output logic [SAMPLE_W-1:0] rd_right,
    output logic [CNT_W-1:0]    level,
    output logic                full,
    output logic                irq
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int PAIR_W = 2 * SAMPLE_W;

    logic             we;
    logic [PTR_W-1:0] waddr;
    logic [PTR_W-1:0] raddr;
    logic             pop;
    logic [PAIR_W-1:0] head_pair;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_valid  (wr_valid),
        .rd_strobe (rd_strobe),
        .we        (we),
        .waddr     (waddr),
        .raddr     (raddr),
        .pop       (pop),
        .count     (level),
        .full_flag (full)
    );

    sfifo_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata ({wr_left, wr_right}),
        .raddr (raddr),
        .rdata (head_pair)
    );

    sfifo_irq #(.DEPTH(DEPTH)) u_irq (
        .mode  (irq_mode),
        .count (level),
        .req   (irq)
    );

    // Captures the oldest pair on each accepted read and holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_left  <= '0;
            rd_right <= '0;
        end else if (pop) begin
            rd_left  <= head_pair[PAIR_W-1:SAMPLE_W];
            rd_right <= head_pair[SAMPLE_W-1:0];
        end
    end

endmodule

// File: rtl/sfifo_chk.sv
// Checker for stereo_sample_fifo: temporal properties on its ports.
module sfifo_chk #(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH    = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic [1:0]          irq_mode,
    input logic                wr_valid,
    input logic                rd_strobe,
    input logic [SAMPLE_W-1:0] rd_left,
    input logic [CNT_W-1:0]    level,
    input logic                full,
    input logic                irq
);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    p_whole_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b01) |-> (irq == (level == CNT_W'(DEPTH))));

    p_one_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b10) |-> (irq == (level != '0)));

    p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH - 1) && wr_valid && !rd_strobe && !clr) |=> full);

    p_read_clears_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && level != '0) |=> !full);

    p_overwrite_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH) && wr_valid && !rd_strobe && !clr)
        |=> (level == CNT_W'(DEPTH) && full));

    p_rdwr_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && wr_valid && level != '0 && !clr) |=> $stable(level));

    p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !wr_valid && level == '0 && !clr)
        |=> ($stable(rd_left) && level == '0));

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0 && !full && $stable(rd_left)));

endmodule

bind stereo_sample_fifo sfifo_chk #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .irq_mode  (irq_mode),
    .wr_valid  (wr_valid),
    .rd_strobe (rd_strobe),
    .rd_left   (rd_left),
    .level     (level),
    .full      (full),
    .irq       (irq)
);

// File: tb/tb_stereo_sample_fifo.sv
module tb_stereo_sample_fifo;
    localparam int W     = 16;
    localparam int DEPTH = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic [1:0] irq_mode = 2'b00;
    logic wr_valid = 1'b0;
    logic [W-1:0] wr_left = '0;
    logic [W-1:0] wr_right = '0;
    logic rd_strobe = 1'b0;
    logic [W-1:0] rd_left;
    logic [W-1:0] rd_right;
    logic [CNT_W-1:0] level;
    logic full;
    logic irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    stereo_sample_fifo #(.SAMPLE_W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .irq_mode(irq_mode),
        .wr_valid(wr_valid), .wr_left(wr_left), .wr_right(wr_right),
        .rd_strobe(rd_strobe), .rd_left(rd_left), .rd_right(rd_right),
        .level(level), .full(full), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock with the given strobes; inputs change 1 ns after the edge.
    task automatic cyc(input bit w, input bit r, input bit c,
                       input logic [W-1:0] l, input logic [W-1:0] rr);
        wr_valid = w; rd_strobe = r; clr = c; wr_left = l; wr_right = rr;
        @(posedge clk); #1;
        wr_valid = 0; rd_strobe = 0; clr = 0;
    endtask

    task automatic push(input logic [W-1:0] l);
        cyc(1, 0, 0, l, ~l);
    endtask

    task automatic pop_expect(input logic [W-1:0] l, input string req);
        cyc(0, 1, 0, '0, '0);
        chk(rd_left == l && rd_right == ~l, req, int'(rd_left), int'(l));
    endtask

    task automatic do_clear();
        cyc(0, 0, 1, '0, '0);
    endtask

    function automatic bit exp_irq(input int m, input int lv);
        case (m)
            1: return lv == DEPTH;
            2: return lv >= 1;
            default: return lv >= DEPTH / 2;
        endcase
    endfunction

    task automatic t_reset();
        chk(level == 0, "R2 level", int'(level), 0);
        chk(!full && !irq, "R2 full/irq", int'({full, irq}), 0);
        chk(rd_left == 0 && rd_right == 0, "R2 data", int'(rd_left), 0);
    endtask

    task automatic t_order();
        do_clear();
        push(16'h1111); push(16'h2222); push(16'h3333);
        chk(level == 3, "R1 level after 3 writes", int'(level), 3);
        pop_expect(16'h1111, "R1 first out");
        cyc(0, 0, 0, '0, '0);
        chk(rd_left == 16'h1111, "R13 output held", int'(rd_left), 16'h1111);
        pop_expect(16'h2222, "R1 second out");
        pop_expect(16'h3333, "R1 third out");
        chk(level == 0, "R1 drained", int'(level), 0);
    endtask

    task automatic sweep_modes(input string tag);
        for (int m = 0; m < 4; m++) begin
            irq_mode = 2'(m); #1;
            chk(irq == exp_irq(m, int'(level)),
                m == 1 ? "R4 whole" : (m == 2 ? "R5 one" : "R3 half"),
                int'(irq), int'(exp_irq(m, int'(level))));
        end
        irq_mode = 2'b00;
    endtask

    task automatic t_modes();
        do_clear();
        sweep_modes("fill");
        for (int k = 1; k <= DEPTH; k++) begin
            push(16'(k));
            sweep_modes("fill");
        end
        for (int k = 1; k <= DEPTH; k++) begin
            irq_mode = 2'b01;
            cyc(0, 1, 0, '0, '0);
            chk(irq == exp_irq(1, int'(level)), "R6 drop on drain", int'(irq),
                int'(exp_irq(1, int'(level))));
            sweep_modes("drain");
        end
    endtask

    task automatic t_overwrite();
        do_clear();
        push(16'hA0); push(16'hB0); push(16'hC0);
        chk(!full, "R7 not full at 3", int'(full), 0);
        push(16'hD0);
        chk(full && level == 4, "R7 full at 4", int'({full, level}), 'h14);
        push(16'hE0);
        chk(full && level == 4, "R9 level kept", int'({full, level}), 'h14);
        pop_expect(16'hA0, "R9 oldest kept");
        chk(!full, "R8 read clears full", int'(full), 0);
        push(16'hF0);
        chk(full, "R7 full again", int'(full), 1);
        push(16'h55);
        pop_expect(16'hB0, "R9 second");
        pop_expect(16'hC0, "R9 third");
        pop_expect(16'hE0, "R9 earlier overwrite");
        pop_expect(16'h55, "R9 newest replaced");
        chk(level == 0, "R9 drained", int'(level), 0);
    endtask

    task automatic t_rdwr();
        do_clear();
        push(16'h10); push(16'h20);
        cyc(1, 1, 0, 16'h30, ~16'h30);
        chk(level == 2 && rd_left == 16'h10, "R10 level held", int'(level), 2);
        push(16'h40); push(16'h50);
        chk(full, "R7 full before rdwr", int'(full), 1);
        cyc(1, 1, 0, 16'h60, ~16'h60);
        chk(level == 4 && !full, "R10 full rdwr level/R8", int'({full, level}), 4);
        chk(rd_left == 16'h20, "R10 oldest out", int'(rd_left), 16'h20);
        pop_expect(16'h30, "R10 order 1");
        pop_expect(16'h40, "R10 order 2");
        pop_expect(16'h50, "R10 order 3");
        pop_expect(16'h60, "R10 appended");
    endtask

    task automatic t_empty_read();
        do_clear();
        cyc(0, 1, 0, '0, '0);
        chk(level == 0 && rd_left == 16'h60 && rd_right == ~16'h60,
            "R11 empty read", int'(rd_left), 16'h60);
    endtask

    task automatic t_clear();
        push(16'h71); push(16'h72); push(16'h73); push(16'h74);
        cyc(1, 1, 1, 16'h99, 16'h99);
        chk(level == 0 && !full && !irq, "R12 cleared", int'({full, level}), 0);
        chk(rd_left == 16'h60, "R12 output kept", int'(rd_left), 16'h60);
        push(16'h81);
        pop_expect(16'h81, "R12 fresh after clear");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_order();
        t_modes();
        t_overwrite();
        t_rdwr();
        t_empty_read();
        t_clear();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule